// File: doc/BRIEF.md
# Fault Address Repair Remapper

This block sits between a memory self-test engine and a small on-chip RAM. While a test runs, the engine reports each failing word as a one-cycle event that carries the word's address. The remapper keeps a small associative table of the distinct failing addresses it has been told about. Each table slot owns one spare word in a reserved region at the top of the address space. For a 256-word memory with 16 slots, that region is 0xF0 to 0xFF.

In functional operation, every access address passes through the remapper. If the address equals a recorded faulty address, it is replaced by that slot's spare address. Any other address passes through unchanged. The lookup is purely combinational, so the remapped address is valid in the same cycle as the access.

Slots are handed out in ascending order. A failing address that is already recorded uses no further slot. When every slot is taken, a new failing address cannot be stored and a sticky flag marks the memory as unrepairable. The table keeps its contents across test runs until reset or an explicit clear.

Top module: `cam_repair_remap`

## Requirements
- R1: After reset no slot is valid: `tbl_full`, `unrepairable` and `repair_active` are 0, and every access address appears unchanged on `map_addr`.
- R2: A fault event (`flt_vld`=1) whose address matches no valid slot is written into the lowest free slot k, counting from 0 upward, at the next rising edge. From the following cycle on, an access to that address yields `map_addr` = 0xF0 + k.
- R3: A fault event whose address already matches a valid slot changes no slot and consumes no slot. The next new address therefore takes the same slot it would have taken without the repeat.
- R4: `tbl_full` is 1 exactly when all 16 slots are valid.
- R5: A fault event with a new address while the table is full stores nothing and sets `unrepairable` to 1, where it stays until a clear or reset. A repeated address while the table is full does not set `unrepairable`.
- R6: An access address that matches no valid slot is driven unchanged onto `map_addr` in the same cycle, with no clock edge in between.
- R7: `repair_active` is 1 exactly when at least one slot is valid.
- R8: `tbl_clear`=1 at a rising edge invalidates all slots and clears `unrepairable`. It takes priority over a fault event in the same cycle, and allocation restarts at slot 0.
- R9: Recorded slots and their redirections persist across idle cycles and later test runs until `tbl_clear` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_clear | input | 1 | Synchronous clear of the whole repair table |
| flt_vld | input | 1 | Fault event from the self-test engine |
| flt_addr | input | 8 | Address of the failing word |
| acc_addr | input | 8 | Functional access address |
| map_addr | output | 8 | Address after repair redirection |
| tbl_full | output | 1 | All slots are in use |
| unrepairable | output | 1 | Sticky: a new fault was lost because the table was full |
| repair_active | output | 1 | At least one redirection is in force |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- at most one slot ever matches an access;
- a live slot is never overwritten;
- a repeated or rejected fault leaves the fill count unchanged, and a rejection raises the unrepairable flag;
- a clear empties the table;
- an unmatched access passes through unchanged, and a matched one lands inside the spare region.

Only the bench scenarios can show which spare word a given address receives. The same holds for the ascending slot order across repeats, persistence over idle time, and the priority of a clear over a simultaneous fault, because each of these depends on a history of events.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

  // Outcome of a fault event at the allocator.
  typedef enum logic [1:0] {
    ALC_IDLE   = 2'd0,
    ALC_DUP    = 2'd1,
    ALC_NEW    = 2'd2,
    ALC_REJECT = 2'd3
  } alc_e;

  // First spare word: the top n words of a 2**aw memory.
  function automatic int unsigned rmp_spare_base(int unsigned aw, int unsigned n);
    return (32'd1 << aw) - n;
  endfunction

  // Spare word owned by slot idx.
  function automatic int unsigned rmp_spare_addr(int unsigned aw, int unsigned n,
                                                 int unsigned idx);
    return rmp_spare_base(aw, n) + idx;
  endfunction

endpackage

// File: rtl/rmp_entry.sv
module rmp_entry #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] flt_addr,
  input  logic [AW-1:0] acc_addr,
  output logic          vld,
  output logic          acc_hit,
  output logic          flt_hit
);

  logic [AW-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      tag_q <= '0;
    end else if (clr) begin
      vld   <= 1'b0;
    end else if (wr_en) begin
      vld   <= 1'b1;
      tag_q <= flt_addr;
    end
  end

  // Two search ports: functional access and incoming fault.
  assign acc_hit = vld && (tag_q == acc_addr);
  assign flt_hit = vld && (tag_q == flt_addr);

  // R3: the allocator never targets a slot that is already live.
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !vld);

  // R8: a clear leaves the slot empty.
  p_clear_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !vld);

endmodule

// File: rtl/rmp_prio.sv
module rmp_prio #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hit_vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IW'(i);
    end
  end

  assign any = |hit_vec;

endmodule

// File: rtl/rmp_alloc.sv
module rmp_alloc
  import rmp_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         flt_vld,
  input  logic         flt_dup,
  output logic [N-1:0] wr_vec,
  output logic         full,
  output logic         unrep
);

  logic [CW-1:0] cnt_q;
  alc_e          decision;

  assign full = (cnt_q == CW'(N));

  always_comb begin
    if (!flt_vld)     decision = ALC_IDLE;
    else if (flt_dup) decision = ALC_DUP;
    else if (full)    decision = ALC_REJECT;
    else              decision = ALC_NEW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      unrep <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      unrep <= 1'b0;
    end else begin
      case (decision)
        ALC_NEW:    cnt_q <= cnt_q + CW'(1);
        ALC_REJECT: unrep <= 1'b1;
        default:    ;
      endcase
    end
  end

  // Fill count is the index of the next free slot.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_wr
      assign wr_vec[g] = (decision == ALC_NEW) && !clr && (cnt_q == CW'(g));
    end
  endgenerate

  // R3: a repeated address leaves the fill count alone.
  p_dup_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decision == ALC_DUP) && !clr |=> $stable(cnt_q));

  // R5: a rejected fault stores nothing and raises the flag.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (decision == ALC_REJECT) && !clr |=> $stable(cnt_q) && unrep);

  // R2: a new fault advances the fill count by exactly one.
  p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (decision == ALC_NEW) && !clr |=> cnt_q == $past(cnt_q) + CW'(1));

  // R8: a clear restarts allocation and drops the flag.
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !unrep);

  // R4: the count never passes the slot total.
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(N));

endmodule

// File: rtl/cam_repair_remap.sv
module cam_repair_remap
  import rmp_pkg::*;
#(
  parameter int AW = 8,
  parameter int N  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_clear,
  input  logic          flt_vld,
  input  logic [AW-1:0] flt_addr,
  input  logic [AW-1:0] acc_addr,
  output logic [AW-1:0] map_addr,
  output logic          tbl_full,
  output logic          unrepairable,
  output logic          repair_active
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);
  localparam logic [AW-1:0] SPARE_BASE = AW'(rmp_spare_base(AW, N));

  logic [N-1:0]  slot_vld;
  logic [N-1:0]  acc_hit_vec;
  logic [N-1:0]  flt_hit_vec;
  logic [N-1:0]  wr_vec;
  logic          acc_any;
  logic [IW-1:0] acc_idx;
  logic          flt_dup;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      rmp_entry #(.AW(AW)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tbl_clear),
        .wr_en    (wr_vec[g]),
        .flt_addr (flt_addr),
        .acc_addr (acc_addr),
        .vld      (slot_vld[g]),
        .acc_hit  (acc_hit_vec[g]),
        .flt_hit  (flt_hit_vec[g])
      );
    end
  endgenerate

  assign flt_dup = |flt_hit_vec;

  rmp_alloc #(.N(N), .CW(CW)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tbl_clear),
    .flt_vld (flt_vld),
    .flt_dup (flt_dup),
    .wr_vec  (wr_vec),
    .full    (tbl_full),
    .unrep   (unrepairable)
  );

  rmp_prio #(.N(N), .IW(IW)) u_prio (
    .hit_vec (acc_hit_vec),
    .any     (acc_any),
    .idx     (acc_idx)
  );

  assign map_addr      = acc_any ? AW'(rmp_spare_addr(AW, N, 32'(acc_idx))) : acc_addr;
  assign repair_active = |slot_vld;

  // R3: duplicate suppression keeps every access to at most one match.
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_hit_vec));

  // R6: an unmatched access is passed through untouched.
  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_any |-> map_addr == acc_addr);

  // R2: a redirected access always lands inside the spare region.
  p_spare_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any |-> map_addr >= SPARE_BASE);

  // R4: a full table implies a redirection is in force.
  p_full_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full |-> repair_active);

endmodule

// File: tb/cam_repair_remap_bench.sv
module cam_repair_remap_bench;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_clear = 1'b0;
  logic       flt_vld = 1'b0;
  logic [7:0] flt_addr = '0;
  logic [7:0] acc_addr = '0;
  logic [7:0] map_addr;
  logic       tbl_full, unrepairable, repair_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  item_t sb_q[$];

  // Bench model: slot index per address (-1 = none), fill count, flag.
  int m_idx [256];
  int m_cnt = 0;
  bit m_unrep = 0;

  always #4 clk = ~clk;

  cam_repair_remap u_cam_repair_remap (
    .clk           (clk),
    .rst_n         (rst_n),
    .tbl_clear     (tbl_clear),
    .flt_vld       (flt_vld),
    .flt_addr      (flt_addr),
    .acc_addr      (acc_addr),
    .map_addr      (map_addr),
    .tbl_full      (tbl_full),
    .unrepairable  (unrepairable),
    .repair_active (repair_active)
  );

  function automatic logic [7:0] model_map(logic [7:0] a);
    if (m_idx[a] >= 0) return 8'(240 + m_idx[a]);
    return a;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 256; i++) m_idx[i] = -1;
    m_cnt   = 0;
    m_unrep = 0;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply a fault event for one cycle and update the model.
  task automatic fault(logic [7:0] a);
    @(negedge clk);
    flt_vld  = 1'b1;
    flt_addr = a;
    if (m_idx[a] < 0) begin
      if (m_cnt < 16) begin
        m_idx[a] = m_cnt;
        m_cnt++;
      end else begin
        m_unrep = 1;
      end
    end
    @(negedge clk);
    flt_vld = 1'b0;
  endtask

  // Driver: apply an access and push its expected mapping.
  task automatic probe(logic [7:0] a, string tag);
    item_t it;
    @(negedge clk);
    acc_addr = a;
    it.addr = a;
    it.exp  = model_map(a);
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_flags(string tag);
    @(negedge clk);
    #3;
    check({tag, " tbl_full"}, tbl_full, (m_cnt == 16) ? 1 : 0);
    check({tag, " unrepairable"}, unrepairable, m_unrep ? 1 : 0);
    check({tag, " repair_active"}, repair_active, (m_cnt > 0) ? 1 : 0);
  endtask

  // Monitor: pop expected items and compare against the output.
  always @(negedge clk) begin
    #3;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check($sformatf("%s map(%02h)", it.tag, it.addr), map_addr, it.exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_flags("R1 reset");
    probe(8'h10, "R1 passthru");
    probe(8'hF0, "R1 passthru spare");

    // R2: first fault takes slot 0
    fault(8'h23);
    probe(8'h23, "R2 slot0");
    probe(8'h24, "R6 neighbour");
    chk_flags("R7 one slot");

    // R3: repeats consume nothing; next new address gets slot 1
    fault(8'h23);
    fault(8'h23);
    fault(8'h05);
    probe(8'h05, "R3 after dup");
    probe(8'h23, "R3 original kept");

    // R6: combinational pass-through, two addresses in back-to-back cycles
    probe(8'h00, "R6 zero");
    probe(8'hFF, "R6 top");

    // R4: fill remaining slots
    for (int k = 0; k < 14; k++) fault(8'h40 + 8'(k * 3));
    chk_flags("R4 full");
    for (int k = 0; k < 14; k++) probe(8'h40 + 8'(k * 3), "R4 fill map");

    // R5: repeat when full does not set the flag
    fault(8'h43);
    chk_flags("R5 dup when full");
    // R5: new address when full is lost and sets sticky flag
    fault(8'h99);
    probe(8'h99, "R5 lost fault");
    chk_flags("R5 overflow");
    fault(8'h9A);
    chk_flags("R5 sticky");

    // R9: persistence across idle cycles
    repeat (40) @(negedge clk);
    probe(8'h23, "R9 persist slot0");
    probe(8'h05, "R9 persist slot1");
    chk_flags("R9 persist flags");

    // R8: clear wins over a simultaneous fault
    @(negedge clk);
    tbl_clear = 1'b1;
    flt_vld   = 1'b1;
    flt_addr  = 8'h77;
    @(negedge clk);
    tbl_clear = 1'b0;
    flt_vld   = 1'b0;
    model_clear();
    chk_flags("R8 cleared");
    probe(8'h77, "R8 fault dropped");
    probe(8'h23, "R8 old slot gone");

    // R8: allocation restarts at slot 0
    fault(8'h77);
    probe(8'h77, "R8 restart slot0");
    chk_flags("R8 restart flags");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule